// File: doc/BRIEF.md
# Multiply-Accumulate Data Arithmetic Unit

This block is the arithmetic core of a fixed-point signal processing datapath. It has two 16-bit operand registers, a signed 16x16 multiplier, and a 32-bit product register. It also holds a bank of two 36-bit accumulators. The accumulators carry four guard bits above the 32-bit product range, so repeated sums can grow past 32 bits without being lost. The multiplier and the accumulate path are pipelined. In one clock the operand registers are multiplied into the product register, and in the same clock the product formed one clock earlier is added into, or subtracted from, a selected accumulator.

An opcode picks the accumulator operation. The operations are: add or subtract the product, load the product, add or subtract the other accumulator, 32-bit AND/OR/XOR with the other accumulator, add a 16-bit word into the high half, and load a 16-bit word into the high half. A squaring control makes the multiplier use the y register for both inputs, so y*y forms in one clock. Every executed operation registers negative, zero, overflow and carry flags, which a sequencer can use for conditional branches. The high half of the selected accumulator is presented as a 16-bit word for storing to memory.

Top module: `mac_dau`

## Requirements
- R1: While `rst_n` is low, both accumulators, the product register, the operand registers and all four flags are zero.
- R2: A clock edge with `mul_en` high and `square` low loads `p_out` with the signed product of the x and y register contents held before that edge. `ld_x`/`ld_y` load `x_in`/`y_in` into those registers on the same edge. With `mul_en` low, `p_out` holds.
- R3: With `mul_en` and `square` both high, `p_out` becomes the square of the y register contents, and the x register has no effect.
- R4: Opcode 1 adds `p_out`, sign-extended from bit 31 to 36 bits, into the accumulator chosen by `acc_sel` (0 or 1). The product register updates on that same edge.
- R5: Opcode 2 subtracts the sign-extended product from the selected accumulator. Opcode 3 loads the sign-extended product into it.
- R6: Accumulator arithmetic is modulo 2^36. Values beyond the signed 32-bit range stay intact in bits 35:32.
- R7: Every operation writes only the selected accumulator. The other accumulator is unchanged.
- R8: Opcodes 4 and 5 add the other accumulator to, or subtract it from, the selected accumulator.
- R9: Opcodes 6, 7 and 8 form the AND, OR and XOR of bits 31:0 of the two accumulators. The 32-bit result is sign-extended from bit 31 into the selected accumulator.
- R10: Opcode 10 places `word_in` in bits 31:16 of the selected accumulator, copies its bit 15 into bits 35:32, and clears bits 15:0. Opcode 9 adds that same 36-bit value to the selected accumulator.
- R11: `word_out` always shows bits 31:16 of the accumulator chosen by the current `acc_sel`.
- R12: Opcodes 1 to 10 register the flags from the 36-bit result:
  - `flag_n` is result bit 35.
  - `flag_z` is set when the result is zero.
  - `flag_v` is set when the result lies outside the signed 32-bit range.
  - `flag_c` is the carry out of bit 35 for opcodes 1, 2, 4, 5 and 9, where a subtraction adds the inverted operand plus one. It is zero for all other opcodes.
  
  Opcode 0 and opcodes 11 to 15 change no accumulator and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_x | input | 1 | Load x register from x_in |
| x_in | input | 16 | x operand value |
| ld_y | input | 1 | Load y register from y_in |
| y_in | input | 16 | y operand value |
| mul_en | input | 1 | Update product register |
| square | input | 1 | Multiplier uses y for both inputs |
| op | input | 4 | Accumulator operation code |
| acc_sel | input | 1 | Destination accumulator |
| word_in | input | 16 | 16-bit word for word load/add |
| acc0 | output | 36 | Accumulator 0 |
| acc1 | output | 36 | Accumulator 1 |
| p_out | output | 32 | Product register |
| word_out | output | 16 | High half of selected accumulator |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | 32-bit overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Both accumulators and the product register are ports, so a wrong internal value shows at the next clock edge after the operation that produced it. A wrong operand register shows one edge later, through `p_out`. A fault in the guard bits stays hidden in the 16-bit word output but shows on the 36-bit accumulator ports and in `flag_v`. A reference model compares every output on every clock, so any difference is reported within one cycle of its cause.

// File: rtl/mac_dau_pkg.sv
package mac_dau_pkg;
   typedef enum logic [3:0] {
      OP_NOP   = 4'd0,
      OP_PADD  = 4'd1,
      OP_PSUB  = 4'd2,
      OP_PLOAD = 4'd3,
      OP_ADDA  = 4'd4,
      OP_SUBA  = 4'd5,
      OP_AND   = 4'd6,
      OP_OR    = 4'd7,
      OP_XOR   = 4'd8,
      OP_ADDW  = 4'd9,
      OP_LOADW = 4'd10
   } dau_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } dau_flags_t;
endpackage

// File: rtl/mac_dau_mult.sv
module mac_dau_mult #(
   parameter int OP_W      = 16,
   parameter bit SQUARE_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld_x,
   input  logic [OP_W-1:0]      x_in,
   input  logic                 ld_y,
   input  logic [OP_W-1:0]      y_in,
   input  logic                 mul_en,
   input  logic                 square,
   output logic [OP_W-1:0]      x_q,
   output logic [OP_W-1:0]      y_q,
   output logic [2*OP_W-1:0]    p_q
);
   localparam int PW = 2 * OP_W;

   logic [OP_W-1:0]      mul_a;
   logic signed [PW-1:0] prod;

   generate
      if (SQUARE_EN) begin : g_sq
         assign mul_a = square ? y_q : x_q;
      end else begin : g_nosq
         logic unused_sq;
         assign unused_sq = square;
         assign mul_a = x_q;
      end
   endgenerate

   assign prod = $signed(mul_a) * $signed(y_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
         p_q <= '0;
      end else begin
         if (ld_x)   x_q <= x_in;
         if (ld_y)   y_q <= y_in;
         if (mul_en) p_q <= prod;
      end
   end
endmodule

// File: rtl/mac_dau_alu.sv
module mac_dau_alu
   import mac_dau_pkg::*;
#(
   parameter int OP_W  = 16,
   parameter int GUARD = 4,
   localparam int PW   = 2 * OP_W,
   localparam int AW   = PW + GUARD
) (
   input  logic [3:0]      op,
   input  logic [AW-1:0]   a,
   input  logic [AW-1:0]   b,
   input  logic [PW-1:0]   p,
   input  logic [OP_W-1:0] word,
   output logic [AW-1:0]   res,
   output dau_flags_t      flags,
   output logic            wr_en
);
   logic [AW-1:0] p_ext, w_ext, addend;
   logic [PW-1:0] lg;
   logic [AW:0]   sum;
   logic          is_sub, is_arith;

   assign p_ext = {{GUARD{p[PW-1]}}, p};
   assign w_ext = {{GUARD{word[OP_W-1]}}, word, {OP_W{1'b0}}};

   always_comb begin
      addend   = b;
      is_sub   = 1'b0;
      is_arith = 1'b0;
      wr_en    = 1'b1;
      lg       = '0;
      unique case (op)
         OP_PADD:  begin addend = p_ext; is_arith = 1'b1; end
         OP_PSUB:  begin addend = p_ext; is_arith = 1'b1; is_sub = 1'b1; end
         OP_ADDA:  begin addend = b;     is_arith = 1'b1; end
         OP_SUBA:  begin addend = b;     is_arith = 1'b1; is_sub = 1'b1; end
         OP_ADDW:  begin addend = w_ext; is_arith = 1'b1; end
         OP_AND:   lg = a[PW-1:0] & b[PW-1:0];
         OP_OR:    lg = a[PW-1:0] | b[PW-1:0];
         OP_XOR:   lg = a[PW-1:0] ^ b[PW-1:0];
         OP_PLOAD, OP_LOADW: ;
         default:  wr_en = 1'b0;
      endcase
   end

   assign sum = {1'b0, a} + {1'b0, (is_sub ? ~addend : addend)} + {{AW{1'b0}}, is_sub};

   always_comb begin
      if (is_arith)              res = sum[AW-1:0];
      else if (op == OP_PLOAD)   res = p_ext;
      else if (op == OP_LOADW)   res = w_ext;
      else                       res = {{GUARD{lg[PW-1]}}, lg};
   end

   assign flags.n = res[AW-1];
   assign flags.z = ~|res;
   assign flags.v = ~((&res[AW-1:PW-1]) | ~(|res[AW-1:PW-1]));
   assign flags.c = is_arith & sum[AW];
endmodule

// File: rtl/mac_dau_accbank.sv
module mac_dau_accbank #(
   parameter int AW      = 36,
   parameter int NUM_ACC = 2,
   localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [SEL_W-1:0]            sel,
   input  logic [AW-1:0]               din,
   output logic [NUM_ACC-1:0][AW-1:0]  acc
);
   generate
      for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         acc[i] <= '0;
            else if (we && sel == SEL_W'(i))    acc[i] <= din;
         end
      end
   endgenerate
endmodule

// File: rtl/mac_dau.sv
module mac_dau
   import mac_dau_pkg::*;
#(
   parameter int OP_W      = 16,
   parameter int GUARD     = 4,
   parameter bit SQUARE_EN = 1'b1,
   localparam int PW       = 2 * OP_W,
   localparam int AW       = PW + GUARD
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_x,
   input  logic [OP_W-1:0] x_in,
   input  logic            ld_y,
   input  logic [OP_W-1:0] y_in,
   input  logic            mul_en,
   input  logic            square,
   input  logic [3:0]      op,
   input  logic            acc_sel,
   input  logic [OP_W-1:0] word_in,
   output logic [AW-1:0]   acc0,
   output logic [AW-1:0]   acc1,
   output logic [PW-1:0]   p_out,
   output logic [OP_W-1:0] word_out,
   output logic            flag_n,
   output logic            flag_z,
   output logic            flag_v,
   output logic            flag_c
);
   localparam int NUM_ACC = 2;

   generate
      if (OP_W < 2) begin : g_bad_opw
         $error("mac_dau: OP_W must be at least 2");
      end
      if (GUARD < 1) begin : g_bad_guard
         $error("mac_dau: GUARD must be at least 1");
      end
   endgenerate

   logic [OP_W-1:0]              x_q, y_q;
   logic [NUM_ACC-1:0][AW-1:0]   acc;
   logic [AW-1:0]                res, a_sel, a_oth;
   dau_flags_t                   nflags, flags_q;
   logic                         wr_en;

   mac_dau_mult #(.OP_W(OP_W), .SQUARE_EN(SQUARE_EN)) i_mult (
      .clk(clk), .rst_n(rst_n), .ld_x(ld_x), .x_in(x_in), .ld_y(ld_y), .y_in(y_in),
      .mul_en(mul_en), .square(square), .x_q(x_q), .y_q(y_q), .p_q(p_out)
   );

   assign a_sel = acc[acc_sel];
   assign a_oth = acc[~acc_sel];

   mac_dau_alu #(.OP_W(OP_W), .GUARD(GUARD)) i_alu (
      .op(op), .a(a_sel), .b(a_oth), .p(p_out), .word(word_in),
      .res(res), .flags(nflags), .wr_en(wr_en)
   );

   mac_dau_accbank #(.AW(AW), .NUM_ACC(NUM_ACC)) i_bank (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .sel(acc_sel), .din(res), .acc(acc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flags_q <= '0;
      else if (wr_en) flags_q <= nflags;
   end

   assign acc0     = acc[0];
   assign acc1     = acc[1];
   assign word_out = a_sel[PW-1:OP_W];
   assign flag_n   = flags_q.n;
   assign flag_z   = flags_q.z;
   assign flag_v   = flags_q.v;
   assign flag_c   = flags_q.c;
endmodule

// File: rtl/mac_dau_chk.sv
module mac_dau_chk #(
   parameter int OP_W  = 16,
   parameter int GUARD = 4,
   localparam int PW   = 2 * OP_W,
   localparam int AW   = PW + GUARD
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mul_en,
   input logic            square,
   input logic [3:0]      op,
   input logic            acc_sel,
   input logic [OP_W-1:0] word_in,
   input logic [OP_W-1:0] x_q,
   input logic [OP_W-1:0] y_q,
   input logic [AW-1:0]   acc0,
   input logic [AW-1:0]   acc1,
   input logic [PW-1:0]   p_out,
   input logic            flag_n,
   input logic            flag_z,
   input logic            flag_v,
   input logic            flag_c
);
   logic [3:0] fl;
   logic       op_live;
   assign fl      = {flag_n, flag_z, flag_v, flag_c};
   assign op_live = (op >= 4'd1) && (op <= 4'd10);

   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (acc0 == '0 && acc1 == '0 && p_out == '0 && fl == 4'b0));

   p_prod_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_en && !square) |=> $signed(p_out) == $signed($past(x_q)) * $signed($past(y_q)));

   p_square_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_en && square) |=> $signed(p_out) == $signed($past(y_q)) * $signed($past(y_q)));

   p_hold_p_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mul_en |=> $stable(p_out));

   p_keep1_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_sel == 1'b0) |=> $stable(acc1));

   p_keep0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_sel == 1'b1) |=> $stable(acc0));

   p_flags_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !op_live |=> $stable(fl));

   p_loadw_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 4'd10 && acc_sel == 1'b0) |=>
         (acc0[OP_W-1:0] == '0 && acc0[PW-1:OP_W] == $past(word_in)));

   p_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (op_live && acc_sel == 1'b0) |=> (flag_z == (acc0 == '0)));
endmodule

bind mac_dau mac_dau_chk #(.OP_W(OP_W), .GUARD(GUARD)) i_chk (
   .clk(clk), .rst_n(rst_n), .mul_en(mul_en), .square(square), .op(op),
   .acc_sel(acc_sel), .word_in(word_in), .x_q(x_q), .y_q(y_q),
   .acc0(acc0), .acc1(acc1), .p_out(p_out),
   .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
);

// File: tb/test_mac_dau.sv
`timescale 1ns/1ps
module test_mac_dau;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_x = 0, ld_y = 0, mul_en = 0, square = 0, acc_sel = 0;
   logic [15:0] x_in = 0, y_in = 0, word_in = 0;
   logic [3:0]  op = 0;
   logic [35:0] acc0, acc1;
   logic [31:0] p_out;
   logic [15:0] word_out;
   logic        flag_n, flag_z, flag_v, flag_c;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   mac_dau i_mac_dau (
      .clk(clk), .rst_n(rst_n), .ld_x(ld_x), .x_in(x_in), .ld_y(ld_y), .y_in(y_in),
      .mul_en(mul_en), .square(square), .op(op), .acc_sel(acc_sel), .word_in(word_in),
      .acc0(acc0), .acc1(acc1), .p_out(p_out), .word_out(word_out),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
   );

   // behavioural reference state
   logic signed [15:0] mx = 0, my = 0;
   logic signed [31:0] mp = 0;
   logic [35:0]        macc [2] = '{36'd0, 36'd0};
   logic [3:0]         mfl = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic compare(input string req);
      chk(acc0 === macc[0], req, "acc0", 64'(acc0), 64'(macc[0]));
      chk(acc1 === macc[1], req, "acc1", 64'(acc1), 64'(macc[1]));
      chk(p_out === mp, req, "p_out", 64'(p_out), 64'(mp));
      chk(word_out === macc[acc_sel][31:16], req, "word_out", 64'(word_out), 64'(macc[acc_sel][31:16]));
      chk({flag_n, flag_z, flag_v, flag_c} === mfl, req, "flags nzvc",
          64'({flag_n, flag_z, flag_v, flag_c}), 64'(mfl));
   endtask

   function automatic logic [35:0] sx32(input logic [31:0] v);
      return {{4{v[31]}}, v};
   endfunction

   task automatic model(input logic lx, input logic [15:0] xv, input logic ly, input logic [15:0] yv,
                        input logic me, input logic sq, input logic [3:0] o, input logic s,
                        input logic [15:0] w);
      logic [35:0] a, b, opnd, r;
      logic [36:0] full;
      logic        c, wr, ar;
      longint      sv;
      a = macc[s]; b = macc[!s]; r = '0; c = 0; wr = 1; ar = 0; opnd = '0;
      case (o)
         4'd1:  begin opnd = sx32(mp); ar = 1; end
         4'd2:  begin opnd = -sx32(mp); ar = 1; end
         4'd4:  begin opnd = b; ar = 1; end
         4'd5:  begin opnd = -b; ar = 1; end
         4'd9:  begin opnd = {{4{w[15]}}, w, 16'h0}; ar = 1; end
         4'd3:  r = sx32(mp);
         4'd10: r = {{4{w[15]}}, w, 16'h0};
         4'd6:  r = sx32(a[31:0] & b[31:0]);
         4'd7:  r = sx32(a[31:0] | b[31:0]);
         4'd8:  r = sx32(a[31:0] ^ b[31:0]);
         default: wr = 0;
      endcase
      if (ar) begin
         if (o == 4'd2 || o == 4'd5)
            full = {1'b0, a} + {1'b0, ~(o == 4'd2 ? sx32(mp) : b)} + 37'd1;
         else
            full = {1'b0, a} + {1'b0, opnd};
         r = full[35:0];
         c = full[36];
      end
      sv = longint'($signed(r));
      if (wr) begin
         macc[s] = r;
         mfl = {r[35], r == 0, (sv > 64'sd2147483647) || (sv < -64'sd2147483648), c};
      end
      if (me) mp = (sq ? my : mx) * my;
      if (lx) mx = xv;
      if (ly) my = yv;
   endtask

   task automatic step(input logic lx, input logic [15:0] xv, input logic ly, input logic [15:0] yv,
                       input logic me, input logic sq, input logic [3:0] o, input logic s,
                       input logic [15:0] w, input string req);
      @(negedge clk);
      ld_x = lx; x_in = xv; ld_y = ly; y_in = yv; mul_en = me; square = sq;
      op = o; acc_sel = s; word_in = w;
      @(posedge clk);
      model(lx, xv, ly, yv, me, sq, o, s, w);
      #1;
      compare(req);
   endtask

   task automatic ldxy(input logic [15:0] xv, input logic [15:0] yv, input string req);
      step(1, xv, 1, yv, 0, 0, 4'd0, 0, 0, req);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 compare("R1");
      @(negedge clk) rst_n = 1;

      // R2: signed multiply of held registers
      ldxy(16'd3, -16'sd5, "R2");
      step(0, 0, 0, 0, 1, 0, 4'd0, 0, 0, "R2");
      ldxy(16'h7FFF, 16'h8000, "R2");
      step(0, 0, 0, 0, 1, 0, 4'd0, 0, 0, "R2");
      step(0, 0, 0, 0, 0, 0, 4'd0, 0, 0, "R2");
      // R3: squaring ignores x
      ldxy(16'd1234, -16'sd300, "R3");
      step(0, 0, 0, 0, 1, 1, 4'd0, 0, 0, "R3");
      // R4 overlap: accumulate previous product while a new one forms
      step(1, 16'd10, 1, 16'd20, 1, 0, 4'd3, 0, 0, "R4");
      step(0, 0, 0, 0, 1, 0, 4'd1, 0, 0, "R4");
      step(0, 0, 0, 0, 1, 0, 4'd1, 1, 0, "R7");
      // R5
      step(0, 0, 0, 0, 0, 0, 4'd2, 0, 0, "R5");
      step(0, 0, 0, 0, 0, 0, 4'd2, 1, 0, "R5");
      // R6: exceed 32 bits with guard bits
      ldxy(16'h8000, 16'h8000, "R6");
      step(0, 0, 0, 0, 1, 0, 4'd0, 0, 0, "R6");
      step(0, 0, 0, 0, 0, 0, 4'd3, 0, 0, "R6");
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, 4'd1, 0, 0, "R6");
      step(0, 0, 0, 0, 0, 0, 4'd10, 1, 16'h7FFF, "R10");
      for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 0, 0, 4'd9, 1, 16'h7FFF, "R6");
      // R8
      step(0, 0, 0, 0, 0, 0, 4'd4, 0, 0, "R8");
      step(0, 0, 0, 0, 0, 0, 4'd5, 1, 0, "R8");
      step(0, 0, 0, 0, 0, 0, 4'd5, 0, 0, "R8");
      // R9
      step(0, 0, 0, 0, 0, 0, 4'd10, 0, 16'hF0F0, "R10");
      step(0, 0, 0, 0, 0, 0, 4'd10, 1, 16'h3C3C, "R10");
      step(0, 0, 0, 0, 0, 0, 4'd9, 1, 16'h0001, "R10");
      step(0, 0, 0, 0, 0, 0, 4'd6, 0, 0, "R9");
      step(0, 0, 0, 0, 0, 0, 4'd7, 1, 0, "R9");
      step(0, 0, 0, 0, 0, 0, 4'd8, 0, 0, "R9");
      // R10 negative word, R11 word select
      step(0, 0, 0, 0, 0, 0, 4'd10, 0, 16'h8001, "R10");
      step(0, 0, 0, 0, 0, 0, 4'd0, 1, 0, "R11");
      step(0, 0, 0, 0, 0, 0, 4'd0, 0, 0, "R11");
      // R12: zero result then idle opcodes keep flags
      step(0, 0, 0, 0, 0, 0, 4'd5, 1, 0, "R12");
      step(0, 0, 0, 0, 0, 0, 4'd8, 0, 0, "R12");
      step(0, 0, 0, 0, 0, 0, 4'd10, 0, 16'h0000, "R12");
      for (int k = 11; k < 16; k++) step(0, 0, 0, 0, 0, 0, 4'(k), 0, 16'h1234, "R12");
      step(0, 0, 0, 0, 0, 0, 4'd0, 1, 16'h1234, "R12");
      // mixed traffic
      for (int i = 0; i < 400; i++)
         step($urandom_range(0, 1), 16'($urandom), $urandom_range(0, 1), 16'($urandom),
              $urandom_range(0, 1), $urandom_range(0, 1), 4'($urandom_range(0, 15)),
              $urandom_range(0, 1), 16'($urandom), "R4");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule